// File: doc/BRIEF.md
# CPU-Side Interrupt Acknowledge Interface

This block sits between an interrupt distributor and one processor core. Each cycle the distributor offers its best candidate (ID, priority, source CPU for software interrupts, valid). The block compares that candidate with a programmable priority threshold and an enable bit, and drives a single registered request line to the core.

Software works through four word registers on a simple request port:
- **Control** sets the enable.
- **Priority mask** sets the threshold.
- **Acknowledge** (read) claims the current candidate and marks it active. It returns a spurious ID when nothing qualifies.
- **End-of-interrupt** (write) retires an active ID.

Acknowledge and end-of-interrupt are reported to the distributor as one-cycle strobes carrying the ID. The distributor uses them to clear pending state and release the source. The ID space has 510 entries; IDs 0 to 15 are software interrupts.

An internal activity map, one bit per ID, blocks a claimed interrupt from being offered again until its end-of-interrupt. The same map filters end-of-interrupt writes, so a write naming an inactive ID does nothing.

Top module: `aif_cpu_ack`

## Requirements
- R1: After reset, irq_o is 0, the control register (address 0) reads 0 and the priority mask register (address 1, bits 7:0) reads 0xF0.
- R2: A read of address 2 while the candidate qualifies returns the ID in bits 9:0. One cycle after the read is accepted, ack_o pulses for one cycle with ack_id_o equal to that ID, and the ID becomes active.
- R3: A read of address 2 while no candidate qualifies returns 1023 (all ID bits set) and produces no ack_o pulse.
- R4: A candidate qualifies only when its 8-bit priority is strictly less than the mask value (unsigned compare), besides the other conditions.
- R5: Control bit 0 enables signalling. While it is 0, irq_o stays 0 and no candidate qualifies.
- R6: A write to address 3 whose bits 9:0 name an active ID makes it inactive. One cycle after the write, eoi_o pulses with eoi_id_o equal to that ID.
- R7: A write to address 3 naming an inactive ID, or an ID of 510 or above, is ignored: no eoi_o pulse and no change of any activity state.
- R8: For an acknowledged ID below 16, bits 12:10 of the read data carry cand_src_i. For other IDs those bits are 0.
- R9: In the cycle after an accepted acknowledge, irq_o is 0. It is then re-evaluated against the next candidate.
- R10: A candidate whose ID is active, or is 510 or above, or whose valid is low, never qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cand_valid_i | input | 1 | Distributor candidate present |
| cand_id_i | input | 10 | Candidate interrupt ID |
| cand_prio_i | input | 8 | Candidate priority, lower is more urgent |
| cand_src_i | input | 3 | Requesting CPU for software interrupts |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 write, 0 read |
| reg_addr_i | input | 2 | Word address: 0 control, 1 mask, 2 acknowledge, 3 end-of-interrupt |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Interrupt request to the core |
| ack_o | output | 1 | Acknowledge strobe to distributor |
| ack_id_o | output | 10 | Acknowledged ID |
| eoi_o | output | 1 | End-of-interrupt strobe to distributor |
| eoi_id_o | output | 10 | Retired ID |

## Verification
The bench offers candidates whose priorities sit on both sides of the mask, including equality. It also offers IDs near and above the 510 limit, valid low, and the enable cleared. This separates a strict compare from an inclusive one and an ID range test from none. Software-interrupt IDs with varied source CPUs are acknowledged, which shows whether the source field is inserted only below 16. End-of-interrupt writes name active, inactive and out-of-range IDs. Afterwards the activity of each ID is observed through whether the same candidate is offered again, which distinguishes a real retire from an ignored write.

// File: rtl/aif_pkg.sv
package aif_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PMASK = 2'd1,
    REG_ACK   = 2'd2,
    REG_EOI   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/aif_qualify.sv
module aif_qualify #(
  parameter int NUM_IDS = 510,
  parameter int ID_W    = 10,
  parameter int PRIO_W  = 8
) (
  input  logic              en_i,
  input  logic [PRIO_W-1:0] mask_i,
  input  logic              valid_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic              active_i,
  output logic              qual_o
);
  localparam logic [ID_W-1:0] ID_LIM = ID_W'(NUM_IDS);

  always_comb begin
    qual_o = en_i && valid_i && (id_i < ID_LIM) && !active_i && (prio_i < mask_i);
  end
endmodule

// File: rtl/aif_active_map.sv
module aif_active_map #(
  parameter int NUM_IDS = 510,
  parameter int ID_W    = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic [ID_W-1:0] set_id_i,
  input  logic            clr_i,
  input  logic [ID_W-1:0] clr_id_i,
  input  logic [ID_W-1:0] cand_id_i,
  input  logic [ID_W-1:0] eoi_id_i,
  output logic            cand_active_o,
  output logic            eoi_active_o
);
  localparam logic [ID_W-1:0] ID_LIM = ID_W'(NUM_IDS);

  logic [NUM_IDS-1:0] act_q;

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    act_q[g] <= 1'b0;
      else if (set_i && set_id_i == ID_W'(g))         act_q[g] <= 1'b1;
      else if (clr_i && clr_id_i == ID_W'(g))         act_q[g] <= 1'b0;
    end
  end

  always_comb begin
    cand_active_o = (cand_id_i < ID_LIM) ? act_q[cand_id_i] : 1'b0;
    eoi_active_o  = (eoi_id_i  < ID_LIM) ? act_q[eoi_id_i]  : 1'b0;
  end
endmodule

// File: rtl/aif_ack_format.sv
module aif_ack_format #(
  parameter int ID_W    = 10,
  parameter int CPU_W   = 3,
  parameter int SGI_NUM = 16,
  parameter int DATA_W  = 32
) (
  input  logic              qual_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [CPU_W-1:0]  src_i,
  output logic [DATA_W-1:0] word_o
);
  localparam logic [ID_W-1:0] SPUR = {ID_W{1'b1}};

  always_comb begin
    word_o = '0;
    if (!qual_i) begin
      word_o[ID_W-1:0] = SPUR;
    end else begin
      word_o[ID_W-1:0] = id_i;
      if (id_i < ID_W'(SGI_NUM)) word_o[ID_W +: CPU_W] = src_i;
    end
  end
endmodule

// File: rtl/aif_cpu_ack.sv
module aif_cpu_ack
  import aif_pkg::*;
#(
  parameter int          NUM_IDS  = 510,
  parameter int          ID_W     = 10,
  parameter int          PRIO_W   = 8,
  parameter int          CPU_W    = 3,
  parameter int          SGI_NUM  = 16,
  parameter int          DATA_W   = 32,
  parameter logic [7:0]  MASK_RST = 8'hF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic [CPU_W-1:0]  cand_src_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              ack_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic              eoi_o,
  output logic [ID_W-1:0]   eoi_id_o
);
  localparam logic [PRIO_W-1:0] MASK_INIT = PRIO_W'(MASK_RST);

  logic              en_q;
  logic [PRIO_W-1:0] mask_q;
  logic              irq_q, ack_q, eoi_q;
  logic [ID_W-1:0]   ack_id_q, eoi_id_q;
  logic [DATA_W-1:0] rdata_q;

  logic              rd_acc, wr_acc, ack_take, eoi_take;
  logic              qual, cand_active, eoi_hit;
  logic [ID_W-1:0]   eoi_id;
  logic [DATA_W-1:0] ack_word;
  reg_sel_e          sel;

  assign sel      = reg_sel_e'(reg_addr_i);
  assign rd_acc   = reg_req_i && !reg_we_i;
  assign wr_acc   = reg_req_i && reg_we_i;
  assign eoi_id   = reg_wdata_i[ID_W-1:0];
  assign ack_take = rd_acc && (sel == REG_ACK) && qual;
  assign eoi_take = wr_acc && (sel == REG_EOI) && eoi_hit;

  aif_qualify #(.NUM_IDS(NUM_IDS), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_qual (
    .en_i     (en_q),
    .mask_i   (mask_q),
    .valid_i  (cand_valid_i),
    .id_i     (cand_id_i),
    .prio_i   (cand_prio_i),
    .active_i (cand_active),
    .qual_o   (qual)
  );

  aif_active_map #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_map (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .set_i         (ack_take),
    .set_id_i      (cand_id_i),
    .clr_i         (eoi_take),
    .clr_id_i      (eoi_id),
    .cand_id_i     (cand_id_i),
    .eoi_id_i      (eoi_id),
    .cand_active_o (cand_active),
    .eoi_active_o  (eoi_hit)
  );

  aif_ack_format #(.ID_W(ID_W), .CPU_W(CPU_W), .SGI_NUM(SGI_NUM), .DATA_W(DATA_W)) u_fmt (
    .qual_i (qual),
    .id_i   (cand_id_i),
    .src_i  (cand_src_i),
    .word_o (ack_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      mask_q   <= MASK_INIT;
      irq_q    <= 1'b0;
      ack_q    <= 1'b0;
      ack_id_q <= '0;
      eoi_q    <= 1'b0;
      eoi_id_q <= '0;
      rdata_q  <= '0;
    end else begin
      // request drops for one cycle after a claim
      irq_q <= qual && !ack_take;
      ack_q <= ack_take;
      eoi_q <= eoi_take;
      if (ack_take) ack_id_q <= cand_id_i;
      if (eoi_take) eoi_id_q <= eoi_id;
      if (wr_acc) begin
        if (sel == REG_CTRL)  en_q   <= reg_wdata_i[0];
        if (sel == REG_PMASK) mask_q <= reg_wdata_i[PRIO_W-1:0];
      end
      if (rd_acc) begin
        unique case (sel)
          REG_CTRL:  rdata_q <= DATA_W'(en_q);
          REG_PMASK: rdata_q <= DATA_W'(mask_q);
          REG_ACK:   rdata_q <= ack_word;
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = irq_q;
  assign ack_o       = ack_q;
  assign ack_id_o    = ack_id_q;
  assign eoi_o       = eoi_q;
  assign eoi_id_o    = eoi_id_q;
endmodule

// File: rtl/aif_cpu_ack_chk.sv
module aif_cpu_ack_chk #(
  parameter int NUM_IDS = 510,
  parameter int ID_W    = 10,
  parameter int PRIO_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_q,
  input logic [PRIO_W-1:0] mask_q,
  input logic [PRIO_W-1:0] cand_prio_i,
  input logic              qual,
  input logic              eoi_hit,
  input logic              reg_req_i,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic              irq_o,
  input logic              ack_o,
  input logic [ID_W-1:0]   ack_id_o,
  input logic              eoi_o
);
  p_irq_off_disabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !irq_o);

  p_irq_drop_after_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !irq_o);

  p_irq_below_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(cand_prio_i) < $past(mask_q)));

  p_spurious_no_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && !reg_we_i && reg_addr_i == 2'd2 && !qual) |=> !ack_o);

  p_eoi_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && reg_we_i && reg_addr_i == 2'd3 && !eoi_hit) |=> !eoi_o);

  p_ack_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (ack_id_o < ID_W'(NUM_IDS)));

  p_strobes_exclusive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ack_o, eoi_o}));
endmodule

bind aif_cpu_ack aif_cpu_ack_chk #(.NUM_IDS(NUM_IDS), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_q        (en_q),
  .mask_q      (mask_q),
  .cand_prio_i (cand_prio_i),
  .qual        (qual),
  .eoi_hit     (eoi_hit),
  .reg_req_i   (reg_req_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .irq_o       (irq_o),
  .ack_o       (ack_o),
  .ack_id_o    (ack_id_o),
  .eoi_o       (eoi_o)
);

// File: tb/sim_aif_cpu_ack.sv
`timescale 1ns/1ps
module sim_aif_cpu_ack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cv = 1'b0;
  logic [9:0]  cid = '0;
  logic [7:0]  cprio = '0;
  logic [2:0]  csrc = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, ack, eoi;
  logic [9:0]  ack_id, eoi_id;

  int total = 0;
  int bad = 0;

  bit       m_act [0:509];
  bit       m_en = 1'b0;
  bit [7:0] m_mask = 8'hF0;

  always #2.5 clk = ~clk;

  aif_cpu_ack u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cand_valid_i(cv), .cand_id_i(cid), .cand_prio_i(cprio), .cand_src_i(csrc),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .ack_o(ack), .ack_id_o(ack_id),
    .eoi_o(eoi), .eoi_id_o(eoi_id)
  );

  function automatic bit is_act(input logic [9:0] id);
    return (id < 10'd510) ? m_act[id] : 1'b0;
  endfunction

  function automatic bit exp_qual();
    return m_en && cv && (cid < 10'd510) && !is_act(cid) && (cprio < m_mask);
  endfunction

  function automatic logic [31:0] exp_ack_word(input bit q);
    logic [31:0] w;
    w = 32'd0;
    if (!q) w[9:0] = 10'h3FF;
    else begin
      w[9:0] = cid;
      if (cid < 10'd16) w[12:10] = csrc;
    end
    return w;
  endfunction

  task automatic chk(input string tg, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tg, what, act, exp);
    end
  endtask

  task automatic cand(input bit v, input logic [9:0] id, input logic [7:0] p, input logic [2:0] s);
    cv = v; cid = id; cprio = p; csrc = s;
  endtask

  // one register cycle, called and returning at a negedge
  task automatic step(input string tg, input bit rq, input bit w, input logic [1:0] a, input logic [31:0] wd);
    bit q, is_ack, is_eoi, ehit;
    logic [31:0] exp_rd;
    logic [9:0] eid;
    q      = exp_qual();
    is_ack = rq && !w && a == 2'd2;
    is_eoi = rq && w && a == 2'd3;
    eid    = wd[9:0];
    ehit   = is_eoi && is_act(eid);
    case (a)
      2'd0:    exp_rd = {31'd0, m_en};
      2'd1:    exp_rd = {24'd0, m_mask};
      2'd2:    exp_rd = exp_ack_word(q);
      default: exp_rd = 32'd0;
    endcase
    req = rq; we = w; addr = a; wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk((is_ack && q) ? "R9" : tg, "irq", {31'd0, irq}, {31'd0, q && !is_ack});
    if (rq && !w) chk(tg, "rdata", rdata, exp_rd);
    if (is_ack) begin
      chk(tg, "ack", {31'd0, ack}, {31'd0, q});
      if (q) chk(tg, "ack_id", {22'd0, ack_id}, {22'd0, cid});
    end
    if (is_eoi) begin
      chk(tg, "eoi", {31'd0, eoi}, {31'd0, ehit});
      if (ehit) chk(tg, "eoi_id", {22'd0, eoi_id}, {22'd0, eid});
    end
    if (is_ack && q) m_act[cid] = 1'b1;
    if (ehit) m_act[eid] = 1'b0;
    if (rq && w && a == 2'd0) m_en = wd[0];
    if (rq && w && a == 2'd1) m_mask = wd[7:0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r;
    for (int i = 0; i < 510; i++) m_act[i] = 1'b0;
    r = $urandom(32'h1f2e3d4c);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "irq reset", {31'd0, irq}, 32'd0);
    step("R1", 1, 0, 2'd0, 0);
    step("R1", 1, 0, 2'd1, 0);

    step("R5", 1, 1, 2'd0, 32'd1);
    cand(1, 10'd40, 8'hEF, 3'd0);
    step("R4", 0, 0, 2'd0, 0);
    step("R4", 0, 0, 2'd0, 0);
    cand(1, 10'd40, 8'hF0, 3'd0);
    step("R4", 0, 0, 2'd0, 0);
    step("R4", 0, 0, 2'd0, 0);

    step("R5", 1, 1, 2'd0, 32'd0);
    cand(1, 10'd41, 8'h10, 3'd0);
    step("R5", 0, 0, 2'd0, 0);
    step("R5", 0, 0, 2'd0, 0);
    step("R3", 1, 0, 2'd2, 0);
    step("R5", 1, 1, 2'd0, 32'd1);

    cand(1, 10'd5, 8'h20, 3'd6);
    step("R2", 0, 0, 2'd0, 0);
    step("R8", 1, 0, 2'd2, 0);
    step("R10", 0, 0, 2'd0, 0);
    step("R10", 1, 0, 2'd2, 0);
    cand(1, 10'd100, 8'h20, 3'd6);
    step("R8", 1, 0, 2'd2, 0);

    step("R7", 1, 1, 2'd3, 32'd7);
    step("R7", 1, 1, 2'd3, 32'd600);
    cand(1, 10'd5, 8'h20, 3'd6);
    step("R7", 0, 0, 2'd0, 0);
    step("R6", 1, 1, 2'd3, 32'd5);
    step("R6", 0, 0, 2'd0, 0);
    step("R6", 0, 0, 2'd0, 0);

    cand(1, 10'd509, 8'h00, 3'd1);
    step("R10", 0, 0, 2'd0, 0);
    step("R2", 1, 0, 2'd2, 0);
    cand(1, 10'd510, 8'h00, 3'd1);
    step("R10", 0, 0, 2'd0, 0);
    step("R10", 1, 0, 2'd2, 0);
    cand(0, 10'd30, 8'h00, 3'd1);
    step("R10", 0, 0, 2'd0, 0);
    step("R3", 1, 0, 2'd2, 0);

    for (int n = 0; n < 600; n++) begin
      int op, sel;
      logic [9:0] id;
      id = ($urandom % 4 == 0) ? 10'(500 + $urandom % 15) : 10'($urandom % 24);
      cand(($urandom % 8) != 0, id, 8'($urandom), 3'($urandom));
      if ($urandom % 3 == 0) cprio = m_mask - 8'($urandom % 2);
      op = $urandom % 8;
      case (op)
        0, 1, 2: step("R2", 1, 0, 2'd2, 0);
        3, 4:    step("R6", 1, 1, 2'd3, 32'($urandom % 26));
        5: begin
          sel = $urandom % 5;
          step("R4", 1, 1, 2'd1, (sel == 0) ? 32'h00 : (sel == 1) ? 32'h10 :
                                  (sel == 2) ? 32'h80 : (sel == 3) ? 32'hF0 : 32'hFF);
        end
        6:       step("R5", 1, 1, 2'd0, {31'd0, ($urandom % 5) != 0});
        default: step("R4", 1, 0, 2'd1, 0);
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule